// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This clocked controller sequences the two switches of a synchronous buck half-bridge. A single PWM command, seen through two threshold comparators, becomes a high-side-on command and a low-side-on command. The two commands are never both active. The dead time between them is not a fixed delay. The controller turns one gate off, then waits until external comparators report that this gate, and where relevant the switch node, have fallen below their sense level. Only then does it turn the other gate on.

All inputs are digital flags from comparators that are already synchronous to the clock. A PWM level that stays between the two thresholds for a programmable number of cycles is read as tri-state, and both gates are forced off. A fallback timer handles short pulses in which the switch node never rose: the low-side gate returns after a fixed time instead of waiting for a switch-node edge that will not come. Both gates stay off until the supply-good flag is asserted. They drop on the next edge whenever that flag goes away.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: While `rstN` is low, both outputs are low. When `supplyOk` is sampled low at a clock edge, both outputs are low after that edge and every internal register returns to its reset value (command tri-state, window count 0, switch-node-seen flag 0, timer 0).
- R2: The PWM flags decode at each edge and are registered one cycle before the sequencer uses them. `pwmAboveHi`=1 with `pwmBelowLo`=0 is a high command. `pwmBelowLo`=1 with `pwmAboveHi`=0 is a low command. Both 0 or both 1 is the window. While the window has lasted fewer than TRI_CYCLES consecutive samples, the previous command is kept.
- R3: At the TRI_CYCLES-th consecutive window sample, the command becomes tri-state. Both outputs are low after the following edge, and they stay low while the window lasts.
- R4: With a high command, the low-side output drops at the next edge. The high-side output rises at the first later edge where `lsGateLow` is sampled 1 while the command is still high.
- R5: With a low command, the high-side output drops at the next edge. If the switch node has been seen high, the low-side output rises at the first edge where both `hsGateLow` and `swNodeLow` are sampled 1. The switch node counts as seen high if `swNodeLow` was sampled 0 at any edge since the low-side output was last on, or if it is 0 now.
- R6: If the switch node has not been seen high, the low-side output does not wait for the switch-node comparator. It rises TO_CYC+1 edges after the high-side output dropped, provided `hsGateLow` is 1 at that edge.
- R7: On leaving tri-state, or after power-up, the controller starts from both outputs off and goes through the same wait states as R4 to R6 toward the new command.
- R8: `hsOn` and `lsOn` are never high in the same cycle.
- R9: TO_CYC equals ceil(TIMEOUT_NS × CLK_HZ / 10^9), and is at least 1. The defaults are 200 ns at 125 MHz, giving 25 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply good; low forces both gates off and clears state |
| pwmAboveHi | input | 1 | PWM input is above the rising threshold |
| pwmBelowLo | input | 1 | PWM input is below the falling threshold |
| lsGateLow | input | 1 | Low-side gate voltage is below the sense level |
| hsGateLow | input | 1 | High-side gate-to-switch-node voltage is below the sense level |
| swNodeLow | input | 1 | Switch-node voltage is below the sense level |
| hsOn | output | 1 | Turn the high-side switch on |
| lsOn | output | 1 | Turn the low-side switch on |

## Verification
The assertions take the comparator flags to be clean, clock-synchronous levels with no unknown values. Each gate-on edge is judged against the flag value sampled one edge earlier. The bench therefore changes every input only on the falling clock edge. The comparator flags come from a small plant model: a gate's low flag falls as soon as that gate is commanded on, and rises a random number of cycles after the gate is released. The switch node follows the high side unless a short-pulse episode holds it low. This keeps the flags physically consistent, while the PWM runs and window lengths are random.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_TRI  = 2'd2
  } pwmCmd_e;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_WAIT_HS = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_WAIT_LS = 3'd3,
    ST_LS_ON   = 3'd4
  } gateState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic tmrRun;   // dead-time fallback timer counts while set
    logic swClr;    // low side conducting: forget any switch-node rise
  } ctrlStrobe_t;

  // conditions from the datapath to the sequencer
  typedef struct packed {
    pwmCmd_e cmd;
    logic    swRisen;
    logic    tmrDone;
  } dpStatus_t;

  function automatic int timeoutCycles(longint unsigned clkHz, longint unsigned ns);
    longint unsigned cyc;
    cyc = (ns * clkHz + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int TRI_CYCLES = 4,
  parameter int TO_CYC     = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        pwmAboveHi,
  input  logic        pwmBelowLo,
  input  logic        swNodeLow,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int WIN_W = (TRI_CYCLES < 2) ? 1 : $clog2(TRI_CYCLES + 1);
  localparam int TMR_W = $clog2(TO_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(TRI_CYCLES - 1);
  localparam logic [WIN_W-1:0] WIN_SAT  = WIN_W'(TRI_CYCLES);
  localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(TO_CYC);

  pwmCmd_e          cmdQ;
  logic [WIN_W-1:0] winCnt;
  logic [TMR_W-1:0] tmrCnt;
  logic             swSeen;
  logic             isHigh;
  logic             isLow;

  assign isHigh = pwmAboveHi & ~pwmBelowLo;
  assign isLow  = pwmBelowLo & ~pwmAboveHi;

  // command register with window qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ   <= CMD_TRI;
      winCnt <= '0;
    end else if (!supplyOk) begin
      cmdQ   <= CMD_TRI;
      winCnt <= '0;
    end else if (isHigh) begin
      cmdQ   <= CMD_HIGH;
      winCnt <= '0;
    end else if (isLow) begin
      cmdQ   <= CMD_LOW;
      winCnt <= '0;
    end else begin
      if (winCnt >= WIN_LAST) cmdQ <= CMD_TRI;
      if (winCnt != WIN_SAT) winCnt <= winCnt + 1'b1;
    end
  end

  // short-pulse fallback timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (!supplyOk || !strobe.tmrRun) begin
      tmrCnt <= '0;
    end else if (tmrCnt != TMR_END) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  // remembers whether the switch node went high since the low side was on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swSeen <= 1'b0;
    end else if (!supplyOk || strobe.swClr) begin
      swSeen <= 1'b0;
    end else if (!swNodeLow) begin
      swSeen <= 1'b1;
    end
  end

  assign status.cmd     = cmdQ;
  assign status.swRisen = swSeen | ~swNodeLow;
  assign status.tmrDone = (tmrCnt == TMR_END);

endmodule

// File: rtl/dtg_control.sv
module dtg_control
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        lsGateLow,
  input  logic        hsGateLow,
  input  logic        swNodeLow,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        hsOn,
  output logic        lsOn
);

  gateState_e stateQ;
  gateState_e stateD;
  logic       lsReady;

  // low side may start once the high side is off and either the switch
  // node has fallen again or, if it never rose, the fallback timer ran out
  assign lsReady = hsGateLow & (status.swRisen ? swNodeLow : status.tmrDone);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_OFF: begin
        if (status.cmd == CMD_HIGH)     stateD = ST_WAIT_HS;
        else if (status.cmd == CMD_LOW) stateD = ST_WAIT_LS;
      end
      ST_WAIT_HS: begin
        if (status.cmd == CMD_TRI)      stateD = ST_OFF;
        else if (status.cmd == CMD_LOW) stateD = ST_WAIT_LS;
        else if (lsGateLow)             stateD = ST_HS_ON;
      end
      ST_HS_ON: begin
        if (status.cmd == CMD_TRI)      stateD = ST_OFF;
        else if (status.cmd == CMD_LOW) stateD = ST_WAIT_LS;
      end
      ST_WAIT_LS: begin
        if (status.cmd == CMD_TRI)       stateD = ST_OFF;
        else if (status.cmd == CMD_HIGH) stateD = ST_WAIT_HS;
        else if (lsReady)                stateD = ST_LS_ON;
      end
      ST_LS_ON: begin
        if (status.cmd == CMD_TRI)       stateD = ST_OFF;
        else if (status.cmd == CMD_HIGH) stateD = ST_WAIT_HS;
      end
      default: stateD = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stateQ <= ST_OFF;
    else if (!supplyOk) stateQ <= ST_OFF;
    else                stateQ <= stateD;
  end

  assign strobe.tmrRun = (stateQ == ST_WAIT_LS);
  assign strobe.swClr  = (stateQ == ST_LS_ON);
  assign hsOn          = (stateQ == ST_HS_ON);
  assign lsOn          = (stateQ == ST_LS_ON);

endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
  import dtg_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd125_000_000,
  parameter longint unsigned TIMEOUT_NS = 64'd200,
  parameter int              TRI_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic pwmAboveHi,
  input  logic pwmBelowLo,
  input  logic lsGateLow,
  input  logic hsGateLow,
  input  logic swNodeLow,
  output logic hsOn,
  output logic lsOn
);

  localparam int TO_CYC = timeoutCycles(CLK_HZ, TIMEOUT_NS);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  dtg_datapath #(
    .TRI_CYCLES (TRI_CYCLES),
    .TO_CYC     (TO_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .pwmAboveHi (pwmAboveHi),
    .pwmBelowLo (pwmBelowLo),
    .swNodeLow  (swNodeLow),
    .strobe     (strobe),
    .status     (status)
  );

  dtg_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .lsGateLow (lsGateLow),
    .hsGateLow (hsGateLow),
    .swNodeLow (swNodeLow),
    .status    (status),
    .strobe    (strobe),
    .hsOn      (hsOn),
    .lsOn      (lsOn)
  );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int TRI_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic pwmAboveHi,
  input logic pwmBelowLo,
  input logic lsGateLow,
  input logic hsGateLow,
  input logic swNodeLow,
  input logic hsOn,
  input logic lsOn
);

  int winRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              winRun <= 0;
    else if (!supplyOk)                     winRun <= 0;
    else if (pwmAboveHi != pwmBelowLo)      winRun <= 0;
    else if (winRun <= TRI_CYCLES)          winRun <= winRun + 1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn)); // R8

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!hsOn && !lsOn)); // R1

  AST_HS_AFTER_LS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> $past(lsGateLow)); // R4

  AST_LS_AFTER_HS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsOn) |-> $past(hsGateLow && swNodeLow)); // R5

  AST_TRI_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (winRun > TRI_CYCLES) |-> (!hsOn && !lsOn)); // R3

endmodule

bind deadtime_gate_ctrl dtg_checker #(.TRI_CYCLES(TRI_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .pwmAboveHi (pwmAboveHi),
  .pwmBelowLo (pwmBelowLo),
  .lsGateLow  (lsGateLow),
  .hsGateLow  (hsGateLow),
  .swNodeLow  (swNodeLow),
  .hsOn       (hsOn),
  .lsOn       (lsOn)
);

// File: tb/deadtime_gate_ctrl_tb.sv
module deadtime_gate_ctrl_tb;

  localparam int TRI_N = 4;
  localparam longint unsigned HZ = 64'd125_000_000;
  localparam longint unsigned NS = 64'd200;
  localparam int TO = int'((NS * HZ + 64'd999_999_999) / 64'd1_000_000_000);

  // reference model state codes
  localparam int S_OFF = 0, S_WHS = 1, S_HS = 2, S_WLS = 3, S_LS = 4;
  localparam int C_LOW = 0, C_HIGH = 1, C_TRI = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic pwmAboveHi = 1'b0;
  logic pwmBelowLo = 1'b0;
  logic lsGateLow = 1'b1;
  logic hsGateLow = 1'b1;
  logic swNodeLow = 1'b1;
  logic hsOn;
  logic lsOn;

  int checks = 0;
  int fails = 0;
  bit shortPulse = 1'b0;

  int mState = S_OFF;
  int mCmd = C_TRI;
  int mWin = 0;
  bit mSwSeen = 1'b0;
  int mTmr = 0;

  always #4 clk = ~clk;

  deadtime_gate_ctrl #(
    .CLK_HZ(HZ), .TIMEOUT_NS(NS), .TRI_CYCLES(TRI_N)
  ) u_dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .pwmAboveHi(pwmAboveHi), .pwmBelowLo(pwmBelowLo),
    .lsGateLow(lsGateLow), .hsGateLow(hsGateLow), .swNodeLow(swNodeLow),
    .hsOn(hsOn), .lsOn(lsOn)
  );

  // cycle model written from the requirements
  always @(posedge clk) begin
    if (!rstN || !supplyOk) begin
      mState = S_OFF; mCmd = C_TRI; mWin = 0; mSwSeen = 1'b0; mTmr = 0;
    end else begin
      bit risen;
      bit ready;
      int nxt;
      risen = mSwSeen || !swNodeLow;
      ready = hsGateLow && (risen ? swNodeLow : (mTmr == TO));
      nxt = mState;
      case (mState)
        S_OFF: if (mCmd == C_HIGH) nxt = S_WHS; else if (mCmd == C_LOW) nxt = S_WLS;
        S_WHS: if (mCmd == C_TRI) nxt = S_OFF; else if (mCmd == C_LOW) nxt = S_WLS;
               else if (lsGateLow) nxt = S_HS;
        S_HS:  if (mCmd == C_TRI) nxt = S_OFF; else if (mCmd == C_LOW) nxt = S_WLS;
        S_WLS: if (mCmd == C_TRI) nxt = S_OFF; else if (mCmd == C_HIGH) nxt = S_WHS;
               else if (ready) nxt = S_LS;
        default: if (mCmd == C_TRI) nxt = S_OFF; else if (mCmd == C_HIGH) nxt = S_WHS;
      endcase
      if (pwmAboveHi && !pwmBelowLo) begin mCmd = C_HIGH; mWin = 0; end
      else if (pwmBelowLo && !pwmAboveHi) begin mCmd = C_LOW; mWin = 0; end
      else begin
        if (mWin >= TRI_N - 1) mCmd = C_TRI;
        if (mWin < TRI_N) mWin++;
      end
      mSwSeen = (mState == S_LS) ? 1'b0 : (mSwSeen || !swNodeLow);
      mTmr = (mState == S_WLS) ? ((mTmr < TO) ? mTmr + 1 : mTmr) : 0;
      mState = nxt;
    end
  end

  function automatic string tagOf();
    if (!rstN || !supplyOk) return "R1";
    if (mCmd == C_TRI) return "R3";
    if (mState == S_WHS || mState == S_HS) return "R4";
    if (mSwSeen) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareModel();
    int expHs;
    int expLs;
    expHs = (mState == S_HS) ? 1 : 0;
    expLs = (mState == S_LS) ? 1 : 0;
    check(hsOn === expHs[0], tagOf(), "hsOn", int'(hsOn), expHs);
    check(lsOn === expLs[0], tagOf(), "lsOn", int'(lsOn), expLs);
    check(!(hsOn && lsOn), "R8", "overlap", int'(hsOn && lsOn), 0);
  endtask

  // plant: gate and switch-node comparators react to the outputs
  task automatic plant();
    if (lsOn) lsGateLow = 1'b0;
    else if (!lsGateLow && ($urandom % 2 == 0)) lsGateLow = 1'b1;
    if (hsOn) hsGateLow = 1'b0;
    else if (!hsGateLow && ($urandom % 2 == 0)) hsGateLow = 1'b1;
    if (hsOn && !shortPulse) begin
      if (swNodeLow && ($urandom % 2 == 0)) swNodeLow = 1'b0;
    end else if (!hsOn && hsGateLow) begin
      if (!swNodeLow && ($urandom % 2 == 0)) swNodeLow = 1'b1;
    end
  endtask

  task automatic setPwm(int lvl);
    if (lvl == C_HIGH) begin pwmAboveHi = 1'b1; pwmBelowLo = 1'b0; end
    else if (lvl == C_LOW) begin pwmAboveHi = 1'b0; pwmBelowLo = 1'b1; end
    else begin
      pwmAboveHi = ($urandom % 2 == 0);
      pwmBelowLo = pwmAboveHi;
    end
  endtask

  task automatic step(int n, int lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareModel();
      plant();
      setPwm(lvl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a;
    int b;
    void'($urandom(32'd4242));
    setPwm(C_HIGH);
    repeat (3) @(negedge clk);
    check(!hsOn && !lsOn, "R1", "outputs in reset", int'({hsOn, lsOn}), 0);
    rstN = 1'b1;
    step(10, C_HIGH);
    check(!hsOn && !lsOn, "R1", "outputs without supply", int'({hsOn, lsOn}), 0);
    supplyOk = 1'b1;

    // R7: from power-up, high command goes through the wait state
    step(12, C_HIGH);
    check(hsOn === 1'b1, "R7", "high side after power-up", int'(hsOn), 1);

    // R2: a short window visit keeps the previous command
    step(TRI_N - 1, C_TRI);
    step(1, C_HIGH);
    check(hsOn === 1'b1, "R2", "short window ignored", int'(hsOn), 1);

    // R3: a long window forces both off
    step(TRI_N + 4, C_TRI);
    check(!hsOn && !lsOn, "R3", "tri-state both off", int'({hsOn, lsOn}), 0);

    // R5: normal fall with switch-node feedback
    step(15, C_HIGH);
    step(15, C_LOW);
    check(lsOn === 1'b1, "R5", "low side after fall", int'(lsOn), 1);

    // R6 and R9: short pulse, switch node never rises
    shortPulse = 1'b1;
    step(10, C_HIGH);
    check(hsOn === 1'b1, "R4", "high side on", int'(hsOn), 1);
    setPwm(C_LOW);
    a = -1; b = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      compareModel();
      plant();
      if (a < 0 && !hsOn) a = i;
      if (b < 0 && lsOn) b = i;
    end
    check(b - a == TO + 1, "R6", "short-pulse wait in cycles", b - a, TO + 1);
    check(TO == 25, "R9", "timeout cycle count", TO, 25);
    shortPulse = 1'b0;

    // R1: supply drop while a gate is on
    step(10, C_HIGH);
    @(negedge clk);
    compareModel();
    supplyOk = 1'b0;
    @(negedge clk);
    check(!hsOn && !lsOn, "R1", "off after supply drop", int'({hsOn, lsOn}), 0);
    mState = S_OFF;
    step(3, C_HIGH);
    supplyOk = 1'b1;

    // random episodes
    for (int e = 0; e < 400; e++) begin
      int r;
      r = $urandom % 10;
      shortPulse = ($urandom % 4 == 0);
      if (r < 2) step(1 + $urandom % (2 * TRI_N), C_TRI);
      else if (r < 6) step(1 + $urandom % 40, C_HIGH);
      else step(1 + $urandom % 40, C_LOW);
      if ($urandom % 50 == 0) begin
        supplyOk = 1'b0;
        step(1 + $urandom % 3, C_HIGH);
        supplyOk = 1'b1;
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule